// File: doc/BRIEF.md
# Dual Windowed Correlation Sum Engine

This block scores how alike two successive video frames are from their luminance histograms. A frame arrives as a 64-bin histogram of 16-bit counts, two bins per 32-bit beat. The engine smooths every bin with its two neighbours to form a windowed term W[b]. It then forms two sums of products. S1 pairs W with the histogram of the same frame. S2 pairs the same W with the histogram of the frame before it. A later stage that takes a square root and divides uses the two sums to build a normalised similarity score.

Six multipliers handle six bins at a time. Each group of windowed terms is held at the multiplier inputs for two cycles. In the first cycle it meets the current histogram, and in the second it meets the previous one. A three-level adder tree reduces the six products, and one accumulator per sum collects the results. The pipeline has six register stages in all. When a frame completes, its histogram becomes the previous-frame operand for the next frame, and its S1 moves to a held output for reuse. S1 is published one cycle before S2, so a downstream stage can start on it early.

Top module: `wcorr_dual_sum`

## Requirements
- R1: A `start_i` high while `busy_o` is low starts a frame and clears both accumulators. `busy_o` is high on the next cycle. A `start_i` while `busy_o` is high has no effect.
- R2: After a start, the block accepts exactly 32 beats, each on a cycle with `data_valid_i` high. Beat k carries bin 2k in bits 15:0 and bin 2k+1 in bits 31:16. Cycles with `data_valid_i` low are not counted. `data_valid_i` outside the load phase is ignored.
- R3: W[b] = H[b-1] + H[b] + H[b+1]. At the ends the edge bin is used twice: W[0] = 2·H[0] + H[1] and W[63] = H[62] + 2·H[63].
- R4: `s1_o` = sum over b of W_n[b]·H_n[b] for the frame just loaded.
- R5: `s2_o` = sum over b of W_n[b]·H_{n-1}[b], where H_{n-1} is the histogram of the previous completed frame. H_{n-1} is all zero after reset.
- R6: `s1_valid_o` is a one-cycle pulse exactly 26 cycles after the clock edge that accepted the last beat. `s2_valid_o` pulses on the next cycle.
- R7: `s1_o` and `s2_o` keep their values until they are next updated, which happens with their valid pulse. When `s1_o` updates, `s1_prev_o` takes the former `s1_o`.
- R8: `busy_o` falls on the same edge that raises `s2_valid_o`. A `start_i` in the last busy cycle is ignored.
- R9: Sums are exact for any 16-bit inputs, including all bins at 0xFFFF, through 40-bit accumulators.
- R10: During and just after reset, `busy_o`, both valid strobes and all sum outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request |
| data_valid_i | input | 1 | Beat qualifier during load |
| data_i | input | 32 | Two histogram bins per beat |
| busy_o | output | 1 | Frame in progress |
| s1_valid_o | output | 1 | Pulse when `s1_o` updates |
| s2_valid_o | output | 1 | Pulse when `s2_o` updates |
| s1_o | output | 64 | Windowed sum against the current histogram |
| s2_o | output | 64 | Windowed sum against the previous histogram |
| s1_prev_o | output | 64 | S1 of the frame before |

## Verification
Two events can fall on the same edge. One is the end of a frame, where S2 is published and the current histogram is copied into the previous bank. The other is a new `start_i`. The bench raises `start_i` in the cycle right after it sees `s1_valid_o`, which is the last busy cycle. The behavioural model rejects that request, so the bench expects `busy_o` to drop and stay low. The next frame that is properly started must then produce an S2 against the histogram that was just copied, and that S2 is compared against the model.

// File: rtl/wcorr_pkg.sv
package wcorr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_DRAIN
  } state_e;

  // issue tag travelling with every product group
  typedef struct packed {
    logic valid;
    logic sel;   // 0: current histogram (S1), 1: previous histogram (S2)
    logic last;
  } tag_t;

endpackage

// File: rtl/wcorr_ctrl.sv
module wcorr_ctrl
  import wcorr_pkg::*;
#(
  parameter int BEATS  = 32,
  parameter int GROUPS = 11,
  parameter int STAGES = 6,
  localparam int ISSUES = 2 * GROUPS,
  localparam int ISS_W  = $clog2(ISSUES),
  localparam int GRP_W  = ISS_W - 1,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int DR_W   = $clog2(STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             data_valid_i,
  output logic             load_en_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic             clr_o,
  output logic [GRP_W-1:0] grp_o,
  output tag_t             tag_o,
  output logic             swap_o,
  output logic             busy_o
);

  state_e            state_q;
  logic [BEAT_W-1:0] beat_q;
  logic [ISS_W-1:0]  issue_q;
  logic [DR_W-1:0]   drain_q;

  assign load_en_o = (state_q == ST_LOAD) && data_valid_i;
  assign clr_o     = (state_q == ST_IDLE) && start_i;
  assign swap_o    = (state_q == ST_DRAIN) && (drain_q == DR_W'(STAGES - 2));
  assign busy_o    = (state_q != ST_IDLE);
  assign beat_o    = beat_q;
  assign grp_o     = issue_q[ISS_W-1:1];

  always_comb begin
    tag_o.valid = (state_q == ST_RUN);
    tag_o.sel   = issue_q[0];
    tag_o.last  = (grp_o == GRP_W'(GROUPS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      issue_q <= '0;
      drain_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOAD;
          beat_q  <= '0;
        end
        ST_LOAD: if (data_valid_i) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == BEAT_W'(BEATS - 1)) begin
            state_q <= ST_RUN;
            issue_q <= '0;
          end
        end
        ST_RUN: begin
          issue_q <= issue_q + 1'b1;
          if (issue_q == ISS_W'(ISSUES - 1)) begin
            state_q <= ST_DRAIN;
            drain_q <= '0;
          end
        end
        ST_DRAIN: begin
          drain_q <= drain_q + 1'b1;
          if (swap_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: idle load cycles do not advance the beat count
  a_r2_beat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && !data_valid_i) |=> $stable(beat_q));

  // R1: an accepted start leads into load
  a_r1_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (state_q == ST_LOAD && beat_q == '0));

endmodule

// File: rtl/wcorr_hist_bank.sv
module wcorr_hist_bank #(
  parameter int BINS   = 64,
  parameter int HIST_W = 16,
  parameter int BUS_W  = 32,
  localparam int PER_BEAT = BUS_W / HIST_W,
  localparam int BEATS    = BINS / PER_BEAT,
  localparam int BEAT_W   = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [BUS_W-1:0]  data_i,
  input  logic              swap_i,
  output logic [HIST_W-1:0] cur_o  [BINS],
  output logic [HIST_W-1:0] prev_o [BINS]
);

  for (genvar i = 0; i < BINS; i++) begin : g_bin
    localparam int BEAT_IDX = i / PER_BEAT;
    localparam int LANE_IDX = i % PER_BEAT;
    logic [HIST_W-1:0] cur_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q  <= '0;
        prev_q <= '0;
      end else begin
        if (load_en_i && beat_i == BEAT_W'(BEAT_IDX))
          cur_q <= data_i[LANE_IDX*HIST_W +: HIST_W];
        if (swap_i)
          prev_q <= cur_q;
      end
    end

    assign cur_o[i]  = cur_q;
    assign prev_o[i] = prev_q;
  end

endmodule

// File: rtl/wcorr_window.sv
module wcorr_window
  import wcorr_pkg::*;
#(
  parameter int BINS   = 64,
  parameter int HIST_W = 16,
  parameter int LANES  = 6,
  parameter int GRP_W  = 4,
  localparam int WIN_W = HIST_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] cur_i  [BINS],
  input  logic [HIST_W-1:0] prev_i [BINS],
  input  logic [GRP_W-1:0]  grp_i,
  input  tag_t              tag_i,
  output logic [WIN_W-1:0]  w_o [LANES],
  output logic [HIST_W-1:0] h_o [LANES],
  output tag_t              tag_o
);

  logic [WIN_W-1:0]  w_n [LANES];
  logic [HIST_W-1:0] h_n [LANES];
  logic [WIN_W-1:0]  w_q [LANES];
  logic [HIST_W-1:0] h_q [LANES];
  tag_t              tag_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      int b, bc, lo, hi;
      b  = int'(grp_i) * LANES + l;
      bc = (b < BINS) ? b : BINS - 1;
      lo = (bc == 0) ? 0 : bc - 1;
      hi = (bc == BINS - 1) ? BINS - 1 : bc + 1;
      if (b < BINS) begin
        w_n[l] = WIN_W'(cur_i[lo]) + WIN_W'(cur_i[bc]) + WIN_W'(cur_i[hi]);
        h_n[l] = tag_i.sel ? prev_i[bc] : cur_i[bc];
      end else begin
        w_n[l] = '0;
        h_n[l] = '0;
      end
    end
  end

  // windowed term loads on the S1 issue and is held through the S2 issue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LANES; l++) begin
        w_q[l] <= '0;
        h_q[l] <= '0;
      end
      tag_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (tag_i.valid && !tag_i.sel) w_q[l] <= w_n[l];
        h_q[l] <= h_n[l];
      end
      tag_q <= tag_i;
    end
  end

  assign w_o   = w_q;
  assign h_o   = h_q;
  assign tag_o = tag_q;

  // R4/R5: every previous-histogram issue directly follows its current-histogram issue
  a_r5_pair_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_q.valid && tag_q.sel) |-> $past(tag_q.valid && !tag_q.sel));

endmodule

// File: rtl/wcorr_mac.sv
module wcorr_mac
  import wcorr_pkg::*;
#(
  parameter int LANES  = 6,
  parameter int HIST_W = 16,
  parameter int ACC_W  = 40,
  parameter int RES_W  = 64,
  localparam int WIN_W  = HIST_W + 2,
  localparam int LEVELS = $clog2(LANES),
  localparam int PAD    = 1 << LEVELS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [WIN_W-1:0]  w_i [LANES],
  input  logic [HIST_W-1:0] h_i [LANES],
  input  tag_t              tag_i,
  output logic [RES_W-1:0]  s1_o,
  output logic [RES_W-1:0]  s2_o,
  output logic [RES_W-1:0]  s1_prev_o,
  output logic              s1_valid_o,
  output logic              s2_valid_o
);

  logic [ACC_W-1:0] prod_q [LANES];
  tag_t             tag_q  [LEVELS+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LANES; l++) prod_q[l] <= '0;
      for (int k = 0; k <= LEVELS; k++) tag_q[k] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) prod_q[l] <= ACC_W'(w_i[l]) * ACC_W'(h_i[l]);
      tag_q[0] <= tag_i;
      for (int k = 1; k <= LEVELS; k++) tag_q[k] <= tag_q[k-1];
    end
  end

  // registered adder tree, one level per cycle
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int N = PAD >> (lv + 1);
    for (genvar j = 0; j < N; j++) begin : g_node
      logic [ACC_W-1:0] a, b, q;
      if (lv == 0) begin : g_leaf
        if (2*j < LANES) begin : g_a
          assign a = prod_q[2*j];
        end else begin : g_az
          assign a = '0;
        end
        if (2*j + 1 < LANES) begin : g_b
          assign b = prod_q[2*j+1];
        end else begin : g_bz
          assign b = '0;
        end
      end else begin : g_inner
        assign a = g_lvl[lv-1].g_node[2*j].q;
        assign b = g_lvl[lv-1].g_node[2*j+1].q;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= a + b;
      end
    end
  end

  logic [ACC_W-1:0] grp_sum;
  tag_t             t_acc;
  logic [ACC_W-1:0] acc1_q, acc2_q;
  logic [RES_W-1:0] s1_q, s2_q, s1_prev_q;
  logic             v1_q, v2_q;

  assign grp_sum = g_lvl[LEVELS-1].g_node[0].q;
  assign t_acc   = tag_q[LEVELS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc1_q    <= '0;
      acc2_q    <= '0;
      s1_q      <= '0;
      s2_q      <= '0;
      s1_prev_q <= '0;
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
    end else begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      if (clr_i) begin
        acc1_q <= '0;
        acc2_q <= '0;
      end else if (t_acc.valid) begin
        if (!t_acc.sel) begin
          acc1_q <= acc1_q + grp_sum;
          if (t_acc.last) begin
            s1_q      <= RES_W'(acc1_q + grp_sum);
            s1_prev_q <= s1_q;
            v1_q      <= 1'b1;
          end
        end else begin
          acc2_q <= acc2_q + grp_sum;
          if (t_acc.last) begin
            s2_q <= RES_W'(acc2_q + grp_sum);
            v2_q <= 1'b1;
          end
        end
      end
    end
  end

  assign s1_o       = s1_q;
  assign s2_o       = s2_q;
  assign s1_prev_o  = s1_prev_q;
  assign s1_valid_o = v1_q;
  assign s2_valid_o = v2_q;

  logic [ACC_W:0] ovf_chk;
  assign ovf_chk = {1'b0, (t_acc.sel ? acc2_q : acc1_q)} + {1'b0, grp_sum};

  // R9: accumulation never carries out of the accumulator width
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_acc.valid |-> !ovf_chk[ACC_W]);

endmodule

// File: rtl/wcorr_dual_sum.sv
module wcorr_dual_sum
  import wcorr_pkg::*;
#(
  parameter int BINS   = 64,
  parameter int HIST_W = 16,
  parameter int BUS_W  = 32,
  parameter int LANES  = 6,
  parameter int ACC_W  = 40,
  parameter int RES_W  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             data_valid_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             busy_o,
  output logic             s1_valid_o,
  output logic             s2_valid_o,
  output logic [RES_W-1:0] s1_o,
  output logic [RES_W-1:0] s2_o,
  output logic [RES_W-1:0] s1_prev_o
);

  localparam int PER_BEAT = BUS_W / HIST_W;
  localparam int BEATS    = BINS / PER_BEAT;
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int GROUPS   = (BINS + LANES - 1) / LANES;
  localparam int ISS_W    = $clog2(2 * GROUPS);
  localparam int GRP_W    = ISS_W - 1;
  localparam int WIN_W    = HIST_W + 2;
  localparam int STAGES   = $clog2(LANES) + 3;

  logic              load_en, clr, swap;
  logic [BEAT_W-1:0] beat;
  logic [GRP_W-1:0]  grp;
  tag_t              iss_tag, win_tag;
  logic [HIST_W-1:0] cur  [BINS];
  logic [HIST_W-1:0] prev [BINS];
  logic [WIN_W-1:0]  w    [LANES];
  logic [HIST_W-1:0] h    [LANES];

  wcorr_ctrl #(.BEATS(BEATS), .GROUPS(GROUPS), .STAGES(STAGES)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .data_valid_i,
    .load_en_o(load_en), .beat_o(beat), .clr_o(clr), .grp_o(grp),
    .tag_o(iss_tag), .swap_o(swap), .busy_o(busy_o)
  );

  wcorr_hist_bank #(.BINS(BINS), .HIST_W(HIST_W), .BUS_W(BUS_W)) u_bank (
    .clk_i, .rst_ni, .load_en_i(load_en), .beat_i(beat), .data_i,
    .swap_i(swap), .cur_o(cur), .prev_o(prev)
  );

  wcorr_window #(.BINS(BINS), .HIST_W(HIST_W), .LANES(LANES), .GRP_W(GRP_W)) u_win (
    .clk_i, .rst_ni, .cur_i(cur), .prev_i(prev), .grp_i(grp),
    .tag_i(iss_tag), .w_o(w), .h_o(h), .tag_o(win_tag)
  );

  wcorr_mac #(.LANES(LANES), .HIST_W(HIST_W), .ACC_W(ACC_W), .RES_W(RES_W)) u_mac (
    .clk_i, .rst_ni, .clr_i(clr), .w_i(w), .h_i(h), .tag_i(win_tag),
    .s1_o, .s2_o, .s1_prev_o, .s1_valid_o, .s2_valid_o
  );

  // R6: S2 follows S1 by exactly one cycle, each as a single pulse
  a_r6_s2_after_s1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_o |=> (s2_valid_o && !s1_valid_o));

  // R8: busy ends together with the S2 strobe
  a_r8_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> s2_valid_o);

  // R7: outputs only move with their strobes
  a_r7_s1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_o |-> $stable(s1_o));
  a_r7_s2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2_valid_o |-> $stable(s2_o));
  a_r7_prev_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_o |-> (s1_prev_o == $past(s1_o)));

endmodule

// File: tb/wcorr_dual_sum_tb_top.sv
module wcorr_dual_sum_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        data_valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        busy_o, s1_valid_o, s2_valid_o;
  logic [63:0] s1_o, s2_o, s1_prev_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  wcorr_dual_sum dut_i (
    .clk_i, .rst_ni, .start_i, .data_valid_i, .data_i,
    .busy_o, .s1_valid_o, .s2_valid_o, .s1_o, .s2_o, .s1_prev_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] corr(input logic [15:0] a[64], input logic [15:0] h[64]);
    longint acc = 0;
    for (int i = 0; i < 64; i++) begin
      longint wl = (i == 0) ? a[0] : a[i-1];
      longint wh = (i == 63) ? a[63] : a[i+1];
      longint w  = wl + longint'(a[i]) + wh;
      acc += w * longint'(h[i]);
    end
    return acc;
  endfunction

  // behavioural reference model, stepped on every edge
  int          m_phase, m_beats, m_cnt;
  logic [15:0] m_cur [64];
  logic [15:0] m_prev[64];
  logic [63:0] m_e1, m_e2, m_s1, m_s2, m_sp;
  logic        m_busy, m_v1, m_v2;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_beats = 0; m_cnt = 0;
      for (int i = 0; i < 64; i++) begin m_cur[i] = '0; m_prev[i] = '0; end
      m_s1 = '0; m_s2 = '0; m_sp = '0; m_e1 = '0; m_e2 = '0;
      m_busy = 0; m_v1 = 0; m_v2 = 0;
    end else begin
      m_v1 = 0; m_v2 = 0;
      case (m_phase)
        0: if (start_i) begin m_phase = 1; m_beats = 0; m_busy = 1; end
        1: if (data_valid_i) begin
          m_cur[2*m_beats]   = data_i[15:0];
          m_cur[2*m_beats+1] = data_i[31:16];
          m_beats++;
          if (m_beats == 32) begin
            m_phase = 2; m_cnt = 0;
            m_e1 = corr(m_cur, m_cur);
            m_e2 = corr(m_cur, m_prev);
          end
        end
        default: begin
          m_cnt++;
          if (m_cnt == 26) begin m_sp = m_s1; m_s1 = m_e1; m_v1 = 1; end
          if (m_cnt == 27) begin
            m_s2 = m_e2; m_v2 = 1; m_busy = 0; m_phase = 0;
            for (int i = 0; i < 64; i++) m_prev[i] = m_cur[i];
          end
        end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R8 busy", {63'd0, busy_o}, {63'd0, m_busy});
      chk("R6 s1_valid", {63'd0, s1_valid_o}, {63'd0, m_v1});
      chk("R6 s2_valid", {63'd0, s2_valid_o}, {63'd0, m_v2});
      chk("R4 s1", s1_o, m_s1);
      chk("R5 s2", s2_o, m_s2);
      chk("R7 s1_prev", s1_prev_o, m_sp);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog act=%0d exp<=100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  logic [15:0] hist [64];

  task automatic send_frame(input bit gaps, input bit start_mid);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R1 busy after start", {63'd0, busy_o}, 64'd1);
    for (int k = 0; k < 32; k++) begin
      if (gaps && (k % 3 == 1)) begin
        data_valid_i = 1'b0; data_i = 32'hDEAD_BEEF;
        @(negedge clk_i);
      end
      start_i = start_mid && (k == 10);
      data_valid_i = 1'b1;
      data_i = {hist[2*k+1], hist[2*k]};
      @(negedge clk_i);
    end
    start_i = 1'b0;
    data_valid_i = 1'b0;
  endtask

  // returns negedges from last beat to the S1 strobe; expects S2 on the next one
  task automatic wait_done(input bit junk, input bit late_start);
    int n = 0;
    while (!s1_valid_o && n < 200) begin
      if (junk) begin data_valid_i = 1'b1; data_i = 32'h1234_5678; end
      @(negedge clk_i); n++;
    end
    data_valid_i = 1'b0;
    chk("R6 s1 latency", 64'(n), 64'd26);
    if (late_start) start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R6 s2 one cycle later", {63'd0, s2_valid_o}, 64'd1);
    chk("R8 busy low with s2", {63'd0, busy_o}, 64'd0);
    @(negedge clk_i);
    chk("R8 late start ignored", {63'd0, busy_o}, 64'd0);
  endtask

  initial begin
    logic [15:0] lf;
    logic [63:0] s1_keep;
    repeat (3) @(negedge clk_i);
    chk("R10 busy in reset", {63'd0, busy_o}, 64'd0);
    chk("R10 s1 in reset", s1_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 s2 after reset", s2_o, 64'd0);
    chk("R10 valids after reset", {62'd0, s1_valid_o, s2_valid_o}, 64'd0);

    // frame 1: pseudo-random, gapped load, no previous frame
    lf = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      hist[i] = lf;
    end
    send_frame(1'b1, 1'b0);
    wait_done(1'b0, 1'b0);
    chk("R5 first frame S2 zero", s2_o, 64'd0);
    chk("R4 random S1", s1_o, corr(hist, hist));
    s1_keep = s1_o;

    // frame 2: all ones, start mid-load ignored
    for (int i = 0; i < 64; i++) hist[i] = 16'hFFFF;
    send_frame(1'b0, 1'b1);
    wait_done(1'b0, 1'b0);
    chk("R9 full-scale S1", s1_o, 64'd64 * 64'd196605 * 64'd65535);
    chk("R7 prev holds earlier S1", s1_prev_o, s1_keep);

    // frame 3: bin 1 and bin 63, stray valid during compute, late start
    for (int i = 0; i < 64; i++) hist[i] = '0;
    hist[1] = 16'd3; hist[63] = 16'd7;
    send_frame(1'b0, 1'b0);
    wait_done(1'b1, 1'b1);
    chk("R2 lane order and R3 top edge", s1_o, 64'd107);

    // frame 4: bin 0 only, uses the bank copied at the collision edge
    for (int i = 0; i < 64; i++) hist[i] = '0;
    hist[0] = 16'd5;
    send_frame(1'b1, 1'b0);
    wait_done(1'b0, 1'b0);
    chk("R3 bottom edge doubled", s1_o, 64'd50);
    chk("R5 previous frame operand", s2_o, 64'd15);
    chk("R7 prev S1", s1_prev_o, 64'd107);

    // frame 5: ramp
    for (int i = 0; i < 64; i++) hist[i] = 16'(i * 977 + 13);
    send_frame(1'b0, 1'b0);
    wait_done(1'b0, 1'b0);
    chk("R4 ramp S1", s1_o, corr(hist, hist));

    repeat (5) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule